// File: doc/BRIEF.md
# Bit-Error Counter with Snapshot Register

This block keeps the error tally of a bit-error-rate tester. A pattern checker upstream presents, on every clock, a strobe saying a received bit is present, a flag saying that bit differed from the expected sequence, and a level saying the checker is locked to the pattern. The block turns these into a running error count, which saturates rather than wrapping. When it saturates, it raises a sticky overflow flag that the host clears by writing one.

The host measures an interval by flipping a single control level. Every flip copies the running count into a 24-bit snapshot register and starts a new interval from zero. Counting is enabled asymmetrically. It begins only when lock is first seen and then carries on through any later loss of lock. If a flip happens while the checker is unlocked, the new interval stays at zero until lock returns.

The snapshot is shown as three byte fields. It can also be read one byte at a time through a small registered read port, which also returns the overflow flag.

Top module: `bert_errcnt`

## Requirements
- R1: The running count rises by exactly one in each counting-enabled cycle in which `bit_vld`=1 and `bit_err`=1. A cycle with `bit_err`=1 and `bit_vld`=0, or with `bit_err`=0, leaves it unchanged.
- R2: After reset, errors are not counted until `sync_ok` is seen high. An error in the first cycle with `sync_ok`=1 is already counted.
- R3: Once counting is enabled, it continues through cycles with `sync_ok`=0.
- R4: The running count stops at 2^CNT_W-1 and never wraps to zero.
- R5: `ovf_sts` goes to 1 in the cycle after the count reaches 2^CNT_W-1. It stays 1 until a cycle with `ovf_clr`=1 clears it. If a new saturation and `ovf_clr` fall in the same cycle, the flag stays 1.
- R6: Any change of `latch_ctl`, either 0 to 1 or 1 to 0, copies the running count into the snapshot, visible on the next cycle. A steady `latch_ctl` leaves the snapshot unchanged.
- R7: A flip clears the running count. An error present in the flip cycle with `sync_ok`=1 counts as the first error of the new interval.
- R8: A flip taken with `sync_ok`=0 holds the running count at zero, ignoring errors, until `sync_ok` is high again.
- R9: Snapshot bits 7:0 appear on `hold_lo`, bits 15:8 on `hold_mid` and bits 23:16 on `hold_hi`. A count narrower than 24 bits is zero-extended.
- R10: `rd_data` is registered. One cycle after `rd_addr` is 0, 1 or 2, it returns the low, middle or high snapshot byte. For `rd_addr`=3 it returns the overflow flag in bit 0 with bits 7:1 at zero.
- R11: Reset clears the running count, the snapshot, the overflow flag and `rd_data`, and leaves counting disabled until lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | A received bit is present this cycle |
| bit_err | input | 1 | The present bit mismatched the expected pattern |
| sync_ok | input | 1 | Pattern checker is locked |
| latch_ctl | input | 1 | Snapshot control level; each flip takes a snapshot |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| rd_addr | input | 2 | Read select: 0 low, 1 middle, 2 high byte, 3 status |
| rd_data | output | 8 | Registered read data |
| hold_lo | output | 8 | Snapshot bits 7:0 |
| hold_mid | output | 8 | Snapshot bits 15:8 |
| hold_hi | output | 8 | Snapshot bits 23:16 |
| ovf_sts | output | 1 | Sticky saturation flag |

## Verification
The hardest state to reach is saturation. At the default 24-bit width it needs millions of error cycles. The bench therefore runs a second instance with a 10-bit counter beside the main one, saturates it twice, and lands a clear strobe exactly on the saturating cycle to test set-over-clear priority. The other subtle cases are the flip taken while unlocked and the error that coincides with a flip. They are reached by ordering the lock level, the error flag and the control flip cycle by cycle. The running count is then read back through the next snapshot.

// File: rtl/bert_pkg.sv
package bert_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned HOLD_BYTES = 3;
    localparam int unsigned HOLD_W     = BYTE_W * HOLD_BYTES;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_MID  = 2'd1,
        SEL_HI   = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        GATE_WAIT = 1'b0,
        GATE_RUN  = 1'b1
    } gate_e;
endpackage

// File: rtl/bert_toggle_det.sv
module bert_toggle_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    typedef struct packed {
        logic lvl;
    } tog_st_t;

    tog_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl;
        pulse    = lvl ^ st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bert_err_core.sv
module bert_err_core
    import bert_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_err,
    input  logic             sync_ok,
    input  logic             latch_pulse,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        gate_e            gate;
        logic             ovf;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     hit;
    logic     live;
    logic     at_max;
    logic     bump;
    logic     sat_evt;

    always_comb begin
        st_d   = st_q;
        hit    = bit_vld & bit_err;
        at_max = (st_q.cnt == CNT_MAX);
        live   = (st_q.gate == GATE_RUN) | sync_ok;
        bump   = 1'b0;

        if (latch_pulse) begin
            // New interval: arm only if locked now; a coincident error opens it.
            st_d.gate = sync_ok ? GATE_RUN : GATE_WAIT;
            st_d.cnt  = (hit && sync_ok) ? CNT_ONE : '0;
        end else begin
            if (sync_ok) st_d.gate = GATE_RUN;
            bump = hit & live & ~at_max;
            if (bump) st_d.cnt = st_q.cnt + CNT_ONE;
        end

        sat_evt = (st_d.cnt == CNT_MAX) && (latch_pulse || !at_max);

        if (sat_evt)      st_d.ovf = 1'b1;
        else if (ovf_clr) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.gate <= GATE_WAIT;
            st_q.ovf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign running = (st_q.gate == GATE_RUN);
    assign ovf     = st_q.ovf;
endmodule

// File: rtl/bert_hold_regs.sv
module bert_hold_regs
    import bert_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_pulse,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ovf,
    input  logic [1:0]        rd_addr,
    output logic [HOLD_W-1:0] hold,
    output logic [BYTE_W-1:0] rd_data
);
    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [BYTE_W-1:0] rd;
    } hold_st_t;

    hold_st_t          st_d, st_q;
    logic [HOLD_W-1:0] cnt_ext;
    logic [BYTE_W-1:0] fld [HOLD_BYTES];

    if (CNT_W < HOLD_W) begin : g_pad
        assign cnt_ext = {{(HOLD_W-CNT_W){1'b0}}, cnt};
    end else begin : g_trim
        assign cnt_ext = cnt[HOLD_W-1:0];
    end

    for (genvar gi = 0; gi < HOLD_BYTES; gi++) begin : g_fld
        assign fld[gi] = st_q.hold[gi*BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d = st_q;
        if (latch_pulse) st_d.hold = cnt_ext;
        case (reg_sel_e'(rd_addr))
            SEL_LO:   st_d.rd = fld[0];
            SEL_MID:  st_d.rd = fld[1];
            SEL_HI:   st_d.rd = fld[2];
            default:  st_d.rd = {{(BYTE_W-1){1'b0}}, ovf};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold    = st_q.hold;
    assign rd_data = st_q.rd;
endmodule

// File: rtl/bert_errcnt.sv
module bert_errcnt
    import bert_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_err,
    input  logic       sync_ok,
    input  logic       latch_ctl,
    input  logic       ovf_clr,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic [7:0] hold_lo,
    output logic [7:0] hold_mid,
    output logic [7:0] hold_hi,
    output logic       ovf_sts
);
    logic              latch_pulse;
    logic [CNT_W-1:0]  cnt_w;
    logic              running_w;
    logic              ovf_w;
    logic [HOLD_W-1:0] hold_w;

    bert_toggle_det u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (latch_ctl),
        .pulse (latch_pulse)
    );

    bert_err_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_vld     (bit_vld),
        .bit_err     (bit_err),
        .sync_ok     (sync_ok),
        .latch_pulse (latch_pulse),
        .ovf_clr     (ovf_clr),
        .cnt         (cnt_w),
        .running     (running_w),
        .ovf         (ovf_w)
    );

    bert_hold_regs #(.CNT_W(CNT_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_pulse (latch_pulse),
        .cnt         (cnt_w),
        .ovf         (ovf_w),
        .rd_addr     (rd_addr),
        .hold        (hold_w),
        .rd_data     (rd_data)
    );

    assign hold_lo  = hold_w[0*BYTE_W +: BYTE_W];
    assign hold_mid = hold_w[1*BYTE_W +: BYTE_W];
    assign hold_hi  = hold_w[2*BYTE_W +: BYTE_W];
    assign ovf_sts  = ovf_w;
endmodule

// File: rtl/bert_errcnt_chk.sv
module bert_errcnt_chk
    import bert_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_vld,
    input logic              bit_err,
    input logic              sync_ok,
    input logic              ovf_clr,
    input logic [1:0]        rd_addr,
    input logic [7:0]        rd_data,
    input logic              ovf_sts,
    input logic [HOLD_W-1:0] hold,
    input logic              latch_pulse,
    input logic [CNT_W-1:0]  cnt,
    input logic              running
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_pulse && cnt != CMAX) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R1

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX && !latch_pulse) |=> (cnt == CMAX)); // R4

    AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_sts) |-> (cnt == CMAX)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sts && !ovf_clr) |=> ovf_sts); // R5

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_pulse |=> $stable(hold)); // R6

    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |=> (hold[CNT_W-1:0] == $past(cnt))); // R6

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_pulse && !(bit_vld && bit_err && sync_ok)) |=> (cnt == '0)); // R7

    AST_WAIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !sync_ok && cnt == '0 && !latch_pulse) |=> (cnt == '0)); // R8

    AST_STAT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd3) |=> (rd_data[7:1] == 7'd0)); // R10
endmodule

bind bert_errcnt bert_errcnt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_vld     (bit_vld),
    .bit_err     (bit_err),
    .sync_ok     (sync_ok),
    .ovf_clr     (ovf_clr),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .ovf_sts     (ovf_sts),
    .hold        (hold_w),
    .latch_pulse (latch_pulse),
    .cnt         (cnt_w),
    .running     (running_w)
);

// File: tb/tb_bert_errcnt.sv
module tb_bert_errcnt;
    localparam int CLK_PERIOD = 10;
    localparam int SMALL_W    = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_err = 1'b0;
    logic       sync_ok = 1'b0;
    logic       latch_ctl = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [1:0] rd_addr = 2'd0;

    logic [7:0] rd_data, hold_lo, hold_mid, hold_hi;
    logic       ovf_sts;
    logic [7:0] s_rd_data, s_lo, s_mid, s_hi;
    logic       s_ovf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bert_errcnt dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_err(bit_err),
        .sync_ok(sync_ok), .latch_ctl(latch_ctl), .ovf_clr(ovf_clr),
        .rd_addr(rd_addr), .rd_data(rd_data), .hold_lo(hold_lo),
        .hold_mid(hold_mid), .hold_hi(hold_hi), .ovf_sts(ovf_sts)
    );

    bert_errcnt #(.CNT_W(SMALL_W)) dut_small (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_err(bit_err),
        .sync_ok(sync_ok), .latch_ctl(latch_ctl), .ovf_clr(ovf_clr),
        .rd_addr(rd_addr), .rd_data(s_rd_data), .hold_lo(s_lo),
        .hold_mid(s_mid), .hold_hi(s_hi), .ovf_sts(s_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(input logic v, input logic e, input logic s, input int n);
        bit_vld = v; bit_err = e; sync_ok = s;
        for (int i = 0; i < n; i++) tick();
        bit_vld = 1'b0; bit_err = 1'b0;
    endtask

    task automatic flip(input logic v, input logic e, input logic s);
        bit_vld = v; bit_err = e; sync_ok = s;
        latch_ctl = ~latch_ctl;
        tick();
        bit_vld = 1'b0; bit_err = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int val);
        rd_addr = a;
        tick();
        val = int'(rd_data);
    endtask

    function automatic int hold24();
        return int'({hold_hi, hold_mid, hold_lo});
    endfunction

    task automatic t_reset();
        int v;
        chk("R11 snapshot after reset", hold24(), 0);
        chk("R11 ovf after reset", int'(ovf_sts), 0);
        chk("R11 rd_data after reset", int'(rd_data), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R10 read after reset", v, 0);
        end
    endtask

    task automatic t_wait_sync();
        step(1, 1, 0, 5);
        flip(0, 0, 0);
        chk("R2 no count before lock", hold24(), 0);
    endtask

    task automatic t_gating();
        step(0, 0, 1, 1);
        step(1, 1, 1, 7);
        step(1, 0, 1, 3);
        step(0, 1, 1, 2);
        step(1, 1, 0, 4);
        flip(0, 0, 0);
        chk("R1 R3 count through lock loss", hold24(), 11);
    endtask

    task automatic t_unlocked_flip();
        step(1, 1, 0, 3);
        step(1, 1, 1, 1);
        step(1, 1, 0, 2);
        flip(1, 1, 1);
        chk("R8 held at zero until lock", hold24(), 3);
    endtask

    task automatic t_flip_edges();
        step(1, 1, 0, 4);
        flip(0, 0, 0);
        chk("R7 coincident error in new interval", hold24(), 5);
        step(1, 1, 1, 2);
        chk("R6 steady level keeps snapshot", hold24(), 5);
        flip(0, 0, 1);
        chk("R6 flip other direction", hold24(), 2);
    endtask

    task automatic t_bytes();
        int v;
        step(1, 1, 1, 300);
        flip(0, 0, 0);
        chk("R9 low byte", int'(hold_lo), 8'h2C);
        chk("R9 mid byte", int'(hold_mid), 8'h01);
        chk("R9 high byte", int'(hold_hi), 0);
        rd(2'd0, v); chk("R10 read low", v, 8'h2C);
        rd(2'd1, v); chk("R10 read mid", v, 8'h01);
        rd(2'd2, v); chk("R10 read high", v, 0);
        rd(2'd3, v); chk("R10 read status", v, 0);
    endtask

    task automatic t_saturate();
        int v;
        flip(0, 0, 1);
        step(1, 1, 1, 1022);
        chk("R5 no ovf below max", int'(s_ovf), 0);
        step(1, 1, 1, 1);
        chk("R5 ovf at max", int'(s_ovf), 1);
        step(1, 1, 1, 5);
        chk("R5 ovf sticky", int'(s_ovf), 1);
        rd_addr = 2'd3;
        tick();
        chk("R10 status bit via read", int'(s_rd_data), 1);
        ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
        chk("R5 clear", int'(s_ovf), 0);
        flip(0, 0, 1);
        chk("R4 no wrap low", int'(s_lo), 8'hFF);
        chk("R4 no wrap mid", int'(s_mid), 8'h03);
        step(1, 1, 1, 1022);
        bit_vld = 1'b1; bit_err = 1'b1; ovf_clr = 1'b1;
        tick();
        bit_vld = 1'b0; bit_err = 1'b0; ovf_clr = 1'b0;
        chk("R5 set wins over clear", int'(s_ovf), 1);
        ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
        chk("R5 clear after collision", int'(s_ovf), 0);
        chk("R5 wide counter not saturated", int'(ovf_sts), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wait_sync();
        t_gating();
        t_unlocked_flip();
        t_flip_edges();
        t_bytes();
        t_saturate();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule